// File: doc/BRIEF.md
# Pipelined Frame Load and Readout Grid

This block moves code frames into and out of a square grid of GRID_K × GRID_K storage elements that sit beside an iterative decoder. Each element owns two banks of soft-symbol storage and two banks of hard-decision storage, DEPTH_L entries each. While the decoder works on the current frame, the next frame's symbols are written into the idle symbol bank, and the decisions of the previous frame are read out of the idle decision bank. A one-cycle swap pulse at each frame boundary exchanges the roles of all banks at once. The result is three frames in flight.

Symbols enter one per cycle with a combined address. The upper field names the target element and the lower field names the entry inside it. The symbol and address travel down each grid column through one register per row. A readout address travels along each grid row through one register per column. Every element appends its decision bit to a bus that widens by one bit per hop. The last column delivers GRID_K words of GRID_K bits, which form the full GRID_K²-bit result. The decoder-facing side is a plain read port for the current symbols and a write port for the current decisions.

Top module: `frame_grid_io`

## Requirements
- R1: While reset is held, `decValid`, `decOut` and `coreIntr` are all zero, and the current bank index is 0.
- R2: `loadAddr` splits into an element field `loadAddr[LOC_W+SEL_W-1:LOC_W]` and an entry field `loadAddr[LOC_W-1:0]`. Element index e = x·GRID_K + y addresses row x, column y. A load whose element field is GRID_K² or larger changes no element.
- R3: A load is written into the idle (next-frame) symbol bank. It is not visible on `coreIntr` until the next `frameSwap`.
- R4: A load keeps the bank that was idle in the cycle it was accepted. This holds even if `frameSwap` is asserted in that same cycle or while the load is still travelling down the column.
- R5: `coreIntr` is registered. One cycle after `coreRdAddr` is sampled, it holds the current-bank symbol of element e at bits [5e+4:5e] (SYM_W = 5).
- R6: A `coreDecWe` cycle writes `coreDecBits[e]` into element e's current decision bank at `coreDecAddr`.
- R7: A read accepted on `rdValid` appears on `decOut` with `decValid` high exactly GRID_K+1 clock edges later. Bit e comes from element e at `rdAddr`. Back-to-back reads produce back-to-back results, and `decOut` is zero whenever `decValid` is low.
- R8: A read uses the idle (previous-frame) decision bank as it was in the cycle the read was accepted, even when `frameSwap` falls in that cycle.
- R9: `frameSwap` toggles the current bank index and nothing else does. Loading, decoder-side decision writes and readout can all occur in the same cycle without disturbing one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frameSwap | input | 1 | Frame boundary pulse; exchanges all banks |
| loadValid | input | 1 | Symbol load strobe |
| loadAddr | input | SEL_W+LOC_W | Element field above entry field |
| loadData | input | SYM_W | Soft symbol to store |
| rdValid | input | 1 | Decision readout strobe |
| rdAddr | input | LOC_W | Entry to read in every element |
| decValid | output | 1 | Readout result valid |
| decOut | output | GRID_K² | Decision bits, bit e from element e |
| coreRdAddr | input | LOC_W | Decoder-side symbol read entry |
| coreIntr | output | GRID_K²·SYM_W | Current-bank symbols, element e at slice e |
| coreDecWe | input | 1 | Decoder-side decision write strobe |
| coreDecAddr | input | LOC_W | Decision write entry |
| coreDecBits | input | GRID_K² | Decision bits, bit e to element e |

## Verification
The risky coincidence is a bank swap in the same cycle as a load or a readout request, or while either is still travelling through the grid. The bench provokes both cases. It asserts `frameSwap` together with a load to a bottom-row element, and again one cycle after such a load. It also pairs a swap with a readout request. It then judges the outcome on the decoder-side read port and on `decOut`, against the bank that was idle when each request was accepted. A final phase drives loading, decision writing and streaming readout in every cycle of a frame, and checks all three results afterwards.

// File: rtl/frame_grid_pkg.sv
`timescale 1ns/1ps
package frame_grid_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic ldEn;      // accept a symbol load this cycle
    logic ldBank;    // bank a new load is stamped with
    logic rdEn;      // accept a readout request this cycle
    logic rdBank;    // bank a new readout is stamped with
    logic coreBank;  // bank the decoder side works on
  } grid_ctl_t;
endpackage

// File: rtl/frame_grid_ctrl.sv
`timescale 1ns/1ps
module frame_grid_ctrl
  import frame_grid_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      frameSwap,
  input  logic      loadValid,
  input  logic      rdValid,
  output grid_ctl_t ctl
);
  logic bankCur;

  always_ff @(posedge clk) begin
    if (rst)            bankCur <= 1'b0;
    else if (frameSwap) bankCur <= ~bankCur;
  end

  always_comb begin
    ctl.ldEn     = loadValid;
    ctl.ldBank   = ~bankCur;
    ctl.rdEn     = rdValid;
    ctl.rdBank   = ~bankCur;
    ctl.coreBank = bankCur;
  end

  a_r9_swap_flips: assert property (@(posedge clk) disable iff (rst)
    frameSwap |=> (bankCur != $past(bankCur)));
  a_r9_bank_holds: assert property (@(posedge clk) disable iff (rst)
    !frameSwap |=> $stable(bankCur));
endmodule

// File: rtl/frame_grid_path.sv
`timescale 1ns/1ps
module frame_grid_path
  import frame_grid_pkg::*;
#(
  parameter int GRID_K  = 3,
  parameter int DEPTH_L = 16,
  parameter int SYM_W   = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  grid_ctl_t                       ctl,
  input  logic [SEL_W+LOC_W-1:0]          loadAddr,
  input  logic [SYM_W-1:0]                loadData,
  input  logic [LOC_W-1:0]                rdAddr,
  output logic                            decValid,
  output logic [GRID_K*GRID_K-1:0]        decOut,
  input  logic [LOC_W-1:0]                coreRdAddr,
  output logic [GRID_K*GRID_K*SYM_W-1:0]  coreIntr,
  input  logic                            coreDecWe,
  input  logic [LOC_W-1:0]                coreDecAddr,
  input  logic [GRID_K*GRID_K-1:0]        coreDecBits
);
  localparam int NPE   = GRID_K * GRID_K;
  localparam int SEL_W = (NPE > 1) ? $clog2(NPE) : 1;
  localparam int LOC_W = (DEPTH_L > 1) ? $clog2(DEPTH_L) : 1;

  typedef struct packed {
    logic             v;
    logic             b;
    logic [SEL_W-1:0] sel;
    logic [LOC_W-1:0] loc;
    logic [SYM_W-1:0] d;
  } ld_stage_t;

  typedef struct packed {
    logic             v;
    logic             b;
    logic [LOC_W-1:0] loc;
  } rd_stage_t;

  ld_stage_t          ldEntry;
  rd_stage_t          rdEntry;
  logic [NPE-1:0]     busAll;
  logic               outV;

  assign ldEntry = '{v: ctl.ldEn, b: ctl.ldBank, sel: loadAddr[LOC_W +: SEL_W],
                     loc: loadAddr[LOC_W-1:0], d: loadData};
  assign rdEntry = '{v: ctl.rdEn, b: ctl.rdBank, loc: rdAddr};

  for (genvar gx = 0; gx < GRID_K; gx++) begin : gRow
    logic [GRID_K-1:0] hitVec;

    for (genvar gy = 0; gy < GRID_K; gy++) begin : gCol
      localparam int IDX = gx * GRID_K + gy;

      ld_stage_t          ldIn, ldQ;
      rd_stage_t          raIn, raQ;
      logic [GRID_K-1:0]  busIn, busQ;
      logic               wrHit;
      logic [SYM_W-1:0]   intrQ;
      logic [SYM_W-1:0]   intrMem [2][DEPTH_L];
      logic [DEPTH_L-1:0] decMem  [2];

      // symbol load travels down the column
      if (gx == 0) begin : gTop
        assign ldIn = ldEntry;
      end else begin : gBelow
        assign ldIn = gRow[gx-1].gCol[gy].ldQ;
      end

      // readout address and widening bus travel along the row
      if (gy == 0) begin : gLeft
        assign raIn  = rdEntry;
        assign busIn = '0;
      end else begin : gRight
        assign raIn  = gRow[gx].gCol[gy-1].raQ;
        assign busIn = gRow[gx].gCol[gy-1].busQ;
      end

      assign wrHit      = ldQ.v && (ldQ.sel == SEL_W'(IDX));
      assign hitVec[gy] = wrHit;

      always_ff @(posedge clk) begin
        if (rst) begin
          ldQ   <= '0;
          raQ   <= '0;
          busQ  <= '0;
          intrQ <= '0;
        end else begin
          ldQ   <= ldIn;
          raQ   <= raIn;
          busQ  <= busIn | (GRID_K'(decMem[raQ.b][raQ.loc]) << gy);
          intrQ <= intrMem[ctl.coreBank][coreRdAddr];
        end
      end

      always_ff @(posedge clk) begin
        if (wrHit)     intrMem[ldQ.b][ldQ.loc] <= ldQ.d;
        if (coreDecWe) decMem[ctl.coreBank][coreDecAddr] <= coreDecBits[IDX];
      end

      assign coreIntr[IDX*SYM_W +: SYM_W] = intrQ;

      if (gy == GRID_K - 1) begin : gTail
        assign busAll[gx*GRID_K +: GRID_K] = busQ;
      end
    end

    // R2: in one row at most one element accepts a given load
    a_r2_single_hit: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hitVec));
  end

  always_ff @(posedge clk) begin
    if (rst) outV <= 1'b0;
    else     outV <= gRow[0].gCol[GRID_K-1].raQ.v;
  end

  assign decValid = outV;
  assign decOut   = outV ? busAll : '0;

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    gRow[0].gCol[GRID_K-1].raQ.v |=> decValid);
  a_r7_valid_source: assert property (@(posedge clk) disable iff (rst)
    decValid |-> $past(gRow[GRID_K-1].gCol[GRID_K-1].raQ.v));
  a_r7_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !decValid |-> (decOut == '0));
endmodule

// File: rtl/frame_grid_io.sv
`timescale 1ns/1ps
module frame_grid_io
  import frame_grid_pkg::*;
#(
  parameter int GRID_K  = 3,
  parameter int DEPTH_L = 16,
  parameter int SYM_W   = 5,
  localparam int NPE    = GRID_K * GRID_K,
  localparam int SEL_W  = (NPE > 1) ? $clog2(NPE) : 1,
  localparam int LOC_W  = (DEPTH_L > 1) ? $clog2(DEPTH_L) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frameSwap,
  input  logic                    loadValid,
  input  logic [SEL_W+LOC_W-1:0]  loadAddr,
  input  logic [SYM_W-1:0]        loadData,
  input  logic                    rdValid,
  input  logic [LOC_W-1:0]        rdAddr,
  output logic                    decValid,
  output logic [NPE-1:0]          decOut,
  input  logic [LOC_W-1:0]        coreRdAddr,
  output logic [NPE*SYM_W-1:0]    coreIntr,
  input  logic                    coreDecWe,
  input  logic [LOC_W-1:0]        coreDecAddr,
  input  logic [NPE-1:0]          coreDecBits
);
  grid_ctl_t ctl;

  frame_grid_ctrl u_ctrl (
    .clk(clk), .rst(rst), .frameSwap(frameSwap),
    .loadValid(loadValid), .rdValid(rdValid), .ctl(ctl)
  );

  frame_grid_path #(.GRID_K(GRID_K), .DEPTH_L(DEPTH_L), .SYM_W(SYM_W)) u_path (
    .clk(clk), .rst(rst), .ctl(ctl),
    .loadAddr(loadAddr), .loadData(loadData), .rdAddr(rdAddr),
    .decValid(decValid), .decOut(decOut),
    .coreRdAddr(coreRdAddr), .coreIntr(coreIntr),
    .coreDecWe(coreDecWe), .coreDecAddr(coreDecAddr), .coreDecBits(coreDecBits)
  );
endmodule

// File: tb/frame_grid_io_tb.sv
`timescale 1ns/1ps
module frame_grid_io_tb;
  localparam int K = 3, L = 16, SW = 5, NPE = 9;

  logic clk = 0, rst = 1, frameSwap = 0, loadValid = 0, rdValid = 0, coreDecWe = 0;
  logic [7:0] loadAddr = 0;
  logic [4:0] loadData = 0;
  logic [3:0] rdAddr = 0, coreRdAddr = 0, coreDecAddr = 0;
  logic [8:0] coreDecBits = 0;
  logic decValid;
  logic [8:0] decOut;
  logic [44:0] coreIntr;

  int nChk = 0, nFail = 0, qHead = 0, qTail = 0;
  bit done = 0;
  logic [8:0] expQ [0:255];

  frame_grid_io u_dut (
    .clk(clk), .rst(rst), .frameSwap(frameSwap), .loadValid(loadValid),
    .loadAddr(loadAddr), .loadData(loadData), .rdValid(rdValid), .rdAddr(rdAddr),
    .decValid(decValid), .decOut(decOut), .coreRdAddr(coreRdAddr), .coreIntr(coreIntr),
    .coreDecWe(coreDecWe), .coreDecAddr(coreDecAddr), .coreDecBits(coreDecBits)
  );

  always #10 clk = ~clk;

  function automatic logic [4:0] symV(int e, int l, int s);
    return 5'((e * 5 + l * 3 + s) % 32);
  endfunction
  function automatic logic [44:0] symRow(int l, int s);
    logic [44:0] r;
    for (int e = 0; e < NPE; e++) r[e*SW +: SW] = symV(e, l, s);
    return r;
  endfunction
  function automatic logic [8:0] decRow(int l, int s);
    logic [8:0] r;
    for (int e = 0; e < NPE; e++) r[e] = ((e * 7 + l * 3 + s) % 5) < 2;
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic loadOne(int sel, int loc, int d, bit swp);
    loadValid = 1; loadAddr = {4'(sel), 4'(loc)}; loadData = 5'(d); frameSwap = swp;
    step();
    loadValid = 0; frameSwap = 0;
  endtask

  task automatic swapNow();
    frameSwap = 1; step(); frameSwap = 0;
  endtask

  task automatic coreRead(int l);
    coreRdAddr = 4'(l); step();
  endtask

  task automatic issueRd(int l, int s, bit swp);
    rdValid = 1; rdAddr = 4'(l); frameSwap = swp;
    expQ[qTail] = decRow(l, s); qTail++;
    step();
    rdValid = 0; frameSwap = 0;
  endtask

  // readout monitor: R7/R8 words in issue order
  always @(negedge clk) begin
    if (!rst && decValid) begin
      if (qHead >= qTail) begin
        nChk++; nFail++;
        $display("FAIL R7 unexpected result: actual %0h expected none", decOut);
      end else begin
        chk("R7 R8 readout word", 64'(decOut), 64'(expQ[qHead]));
      end
      qHead++;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 decValid in reset", 64'(decValid), 0);
    chk("R1 decOut in reset", 64'(decOut), 0);
    chk("R1 coreIntr in reset", 64'(coreIntr), 0);
    rst = 0;
    step();

    // R2: full frame into the idle bank, plus out-of-range selects
    for (int e = 0; e < NPE; e++)
      for (int l = 0; l < L; l++) loadOne(e, l, symV(e, l, 1), 0);
    for (int s = NPE; s < 16; s++) loadOne(s, s - NPE, 31, 0);
    repeat (K + 1) step();
    swapNow();
    for (int l = 0; l < L; l++) begin
      coreRead(l);
      chk("R2 R5 symbol row", 64'(coreIntr), 64'(symRow(l, 1)));
    end

    // R3: new load hidden until swap
    loadOne(4, 2, 7, 0);
    repeat (K + 1) step();
    coreRead(2);
    chk("R3 before swap", 64'(coreIntr[20 +: 5]), 64'(symV(4, 2, 1)));
    swapNow();
    coreRead(2);
    chk("R3 after swap", 64'(coreIntr[20 +: 5]), 7);

    // R4: swap in the load cycle, then swap during flight
    loadOne(7, 5, 19, 1);
    repeat (K + 1) step();
    coreRead(5);
    chk("R4 swap with load", 64'(coreIntr[35 +: 5]), 19);
    loadOne(8, 6, 11, 0);
    swapNow();
    repeat (K + 1) step();
    coreRead(6);
    chk("R4 swap in flight", 64'(coreIntr[40 +: 5]), 11);

    // R6: decoder-side decision writes, then readout of previous frame
    for (int l = 0; l < L; l++) begin
      coreDecWe = 1; coreDecAddr = 4'(l); coreDecBits = decRow(l, 3); step();
    end
    coreDecWe = 0;
    swapNow();
    for (int l = 0; l < L; l++) begin
      coreDecWe = 1; coreDecAddr = 4'(l); coreDecBits = decRow(l, 5); step();
    end
    coreDecWe = 0;
    for (int l = 0; l < L; l++) issueRd(l, 3, 0);   // R6 R7 back-to-back
    repeat (K + 2) step();

    // R7: exact latency
    issueRd(9, 3, 0);
    repeat (K - 1) step();
    chk("R7 not early", 64'(decValid), 0);
    step();
    chk("R7 on time", 64'(decValid), 1);
    step();

    // R8: readout with swap in the same cycle keeps the old bank
    issueRd(4, 3, 1);
    issueRd(4, 5, 0);
    repeat (K + 2) step();

    // R9: load, decision write and readout in every cycle
    for (int l = 0; l < L; l++) begin
      loadValid = 1; loadAddr = {4'(l % NPE), 4'(l)}; loadData = symV(l % NPE, l, 9);
      coreDecWe = 1; coreDecAddr = 4'(l); coreDecBits = decRow(l, 7);
      rdValid = 1; rdAddr = 4'(l); expQ[qTail] = decRow(l, 5); qTail++;
      step();
    end
    loadValid = 0; coreDecWe = 0; rdValid = 0;
    repeat (K + 2) step();
    swapNow();
    for (int l = 0; l < L; l++) begin
      coreRead(l);
      chk("R9 overlapped load", 64'(coreIntr[(l % NPE)*SW +: SW]), 64'(symV(l % NPE, l, 9)));
    end
    for (int l = 0; l < L; l++) issueRd(l, 7, 0);
    repeat (K + 2) step();
    chk("R7 all reads returned", 64'(qHead), 64'(qTail));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule